// File: doc/BRIEF.md
# PWM Fault Input Conditioner

This block takes six external fault lines for a PWM controller and turns each into an active-fault status flag. Each line has three settings of its own. A polarity bit selects which level counts as a fault. A filter enable makes the line hold its new level for three clock cycles before the change is accepted. A mode bit chooses between a flag that follows the fault and a flag that latches it. A latched flag stays set until the line has gone inactive and software has written a 1 to that line's bit of the clear register. A single combined output, the OR of all flags, is provided for the logic that drives the PWM outputs to safe levels.

Software reaches the block through a simple register port with a write strobe, an address and write data, plus a combinational read-data path. Address 0 holds the mode word, address 1 returns the flags and address 2 is the write-only clear register. Two lock inputs, one driven by software protection logic and one by hardware protection logic, each block writes to the mode word while asserted.

Top module: `pwm_fault_cond`

## Requirements
- R1: Input c is in its fault state when fault_i[c] equals polarity bit c of the mode word (bits 7:0, bit c for input c). Polarity 0 means the fault is active low and polarity 1 means it is active high.
- R2: With the filter bit of input c at 0, a change of fault_i[c] reaches flag_o[c] on the third rising clock edge after the change, through a two-stage synchroniser and the flag register.
- R3: With filter bit c at 1 (mode word bits 23:16), the synchronised level must hold for three consecutive cycles before it is accepted, and it then reaches flag_o[c] on the sixth rising edge after the input change. A pulse that lasts two cycles or less never reaches the flag.
- R4: With mode bit c at 0 (mode word bits 15:8), flag_o[c] follows the fault state and drops as soon as the input returns to its inactive level.
- R5: With mode bit c at 1, flag_o[c] stays set after the input goes inactive. It drops on the clock edge that accepts a write to address 2 with data bit c at 1 while the input is inactive.
- R6: A clear write made while the latched input is still in its fault state has no effect. The flag stays set, and the clear is not remembered for later.
- R7: A write to address 0 is ignored while wp_sw_i or wp_hw_i is high, and the mode word reads back unchanged.
- R8: A read of address 0 returns the polarity, mode and filter fields in bits 5:0, 13:8 and 21:16, with all other bits 0. A read of address 1 returns the flags in bits 5:0. A read of address 2 returns 0.
- R9: fault_any_o is high exactly when at least one status flag is set.
- R10: After reset every field of the mode word is 0, every flag is clear and no write is blocked unless a lock input is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fault_i | input | 6 | Raw external fault lines |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0 mode, 1 status, 2 clear) |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, combinational on addr_i |
| wp_sw_i | input | 1 | Software write lock for the mode word |
| wp_hw_i | input | 1 | Hardware write lock for the mode word |
| flag_o | output | 6 | Per-input active-fault status flags |
| fault_any_o | output | 1 | OR of all status flags |

## Verification
The hardest case to reach is a latched flag that gets a clear while its line is still faulty and then keeps its set state once the line goes quiet. The stimulus holds the line active until the flag is set, writes the clear during the fault, releases the line and waits several cycles, and only then writes a second clear. Filter rejection is driven with pulses timed to two cycles of the synchronised level. A long random phase then mixes line toggles, locked and unlocked mode writes and clears, and a behavioural model compares the flags on every cycle.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;
  localparam int unsigned N_FAULT = 6;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned POL_LSB = 0;
  localparam int unsigned MOD_LSB = 8;
  localparam int unsigned FIL_LSB = 16;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_MODE = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_CLR  = 2'd2
  } addr_e;

  typedef struct packed {
    logic [N_FAULT-1:0] fil;
    logic [N_FAULT-1:0] mode;
    logic [N_FAULT-1:0] pol;
  } cfg_t;
endpackage

// File: rtl/fault_sync.sv
module fault_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/fault_filter.sv
module fault_filter #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned CNT_W = $clog2(FILT_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      q_q   <= 1'b0;
    end else if (d_i == q_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      q_q   <= d_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign q_o = q_q;

  // output moves only after the new level was seen on the last three samples
  assert_filter_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(q_q) |-> ($past(d_i) == q_q && $past(d_i, 2) == q_q && $past(d_i, 3) == q_q));
endmodule

// File: rtl/fault_flag.sv
module fault_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic det_i,
  input  logic latch_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (latch_i) flag_q <= det_i | (flag_q & ~clr_i);
    else              flag_q <= det_i;
  end

  assign flag_o = flag_q;

  assert_fall_inactive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> !$past(det_i));

  assert_fall_needs_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(flag_q) && $past(latch_i)) |-> $past(clr_i));

  assert_clear_while_active_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_i && det_i && clr_i) |=> flag_q);
endmodule

// File: rtl/pwm_fault_cond.sv
module pwm_fault_cond
  import pwm_fault_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_FAULT-1:0] fault_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  input  logic               wp_sw_i,
  input  logic               wp_hw_i,
  output logic [N_FAULT-1:0] flag_o,
  output logic               fault_any_o
);
  cfg_t               cfg_q;
  logic               locked;
  logic               wr_mode;
  logic [N_FAULT-1:0] clr_vec;

  assign locked  = wp_sw_i | wp_hw_i;
  assign wr_mode = wr_en_i && (addr_e'(addr_i) == ADDR_MODE) && !locked;
  assign clr_vec = (wr_en_i && (addr_e'(addr_i) == ADDR_CLR)) ? wdata_i[N_FAULT-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_mode) begin
      cfg_q.pol  <= wdata_i[POL_LSB +: N_FAULT];
      cfg_q.mode <= wdata_i[MOD_LSB +: N_FAULT];
      cfg_q.fil  <= wdata_i[FIL_LSB +: N_FAULT];
    end
  end

  for (genvar g = 0; g < N_FAULT; g++) begin : g_ch
    logic lvl, lvl_sync, lvl_filt, det;

    // polarity folded in ahead of the synchroniser so reset state reads inactive
    assign lvl = fault_i[g] ~^ cfg_q.pol[g];

    fault_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i), .rst_ni(rst_ni), .d_i(lvl), .q_o(lvl_sync)
    );

    fault_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i (clk_i), .rst_ni(rst_ni), .d_i(lvl_sync), .q_o(lvl_filt)
    );

    assign det = cfg_q.fil[g] ? lvl_filt : lvl_sync;

    fault_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .det_i  (det),
      .latch_i(cfg_q.mode[g]),
      .clr_i  (clr_vec[g]),
      .flag_o (flag_o[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_e'(addr_i))
      ADDR_MODE: begin
        rdata_o[POL_LSB +: N_FAULT] = cfg_q.pol;
        rdata_o[MOD_LSB +: N_FAULT] = cfg_q.mode;
        rdata_o[FIL_LSB +: N_FAULT] = cfg_q.fil;
      end
      ADDR_STAT: rdata_o[N_FAULT-1:0] = flag_o;
      default:   rdata_o = '0;
    endcase
  end

  assign fault_any_o = |flag_o;

  assert_locked_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_e'(addr_i) == ADDR_MODE && locked) |=> $stable(cfg_q));

  assert_any_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_any_o) |-> ($countones(flag_o) > 0 && !$past(|flag_o)));
endmodule

// File: tb/sim_pwm_fault_cond.sv
module sim_pwm_fault_cond;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  fault_i = 6'h3F;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [31:0] wdata_i = 32'h0;
  logic        wp_sw_i = 1'b0;
  logic        wp_hw_i = 1'b0;
  logic [31:0] rdata_o;
  logic [5:0]  flag_o;
  logic        fault_any_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  pwm_fault_cond u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .fault_i(fault_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .wp_sw_i(wp_sw_i),
    .wp_hw_i(wp_hw_i), .flag_o(flag_o), .fault_any_o(fault_any_o)
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  // behavioural reference
  bit [5:0] m_pol = '0, m_mod = '0, m_fil = '0, m_flag = '0, m_filt = '0;
  bit       hist [6][4];

  always @(posedge clk_i or negedge rst_ni) begin : ref_model
    bit [5:0] clrv;
    bit lvl, det;
    if (!rst_ni) begin
      m_pol = '0; m_mod = '0; m_fil = '0; m_flag = '0; m_filt = '0;
      for (int c = 0; c < 6; c++) for (int k = 0; k < 4; k++) hist[c][k] = 1'b0;
    end else begin
      clrv = (wr_en_i && addr_i == 2'd2) ? wdata_i[5:0] : 6'h0;
      for (int c = 0; c < 6; c++) begin
        lvl = (fault_i[c] == m_pol[c]);
        det = m_fil[c] ? m_filt[c] : hist[c][1];
        m_flag[c] = m_mod[c] ? (det | (m_flag[c] & ~clrv[c])) : det;
        if (hist[c][1] == hist[c][2] && hist[c][2] == hist[c][3]) m_filt[c] = hist[c][1];
        for (int k = 3; k > 0; k--) hist[c][k] = hist[c][k-1];
        hist[c][0] = lvl;
      end
      if (wr_en_i && addr_i == 2'd0 && !wp_sw_i && !wp_hw_i) begin
        m_pol = wdata_i[5:0]; m_mod = wdata_i[13:8]; m_fil = wdata_i[21:16];
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R2/R3/R4/R5 flags vs model", {26'h0, flag_o}, {26'h0, m_flag});
      chk("R9 fault_any", {31'h0, fault_any_o}, {31'h0, |m_flag});
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    tick(1);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    addr_i = a;
    #1;
    v = rdata_o;
  endtask

  function automatic logic [31:0] mword(input bit [5:0] p, input bit [5:0] m, input bit [5:0] f);
    return {8'h00, 2'b00, f, 2'b00, m, 2'b00, p};
  endfunction

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk_i);
    #1 rst_ni = 1'b1;
    tick(1);

    // R10 reset state
    rd(2'd0, v);
    chk("R10 mode word after reset", v, 32'h0);
    chk("R10 flags after reset", {26'h0, flag_o}, 32'h0);

    // R1 R2 R4: active-low input 0, unfiltered, follow mode
    fault_i[0] = 1'b0;
    tick(2);
    chk("R2 flag0 not before third edge", {31'h0, flag_o[0]}, 32'h0);
    tick(1);
    chk("R2 flag0 on third edge", {31'h0, flag_o[0]}, 32'h1);
    fault_i[0] = 1'b1;
    tick(3);
    chk("R4 flag0 follows release", {31'h0, flag_o[0]}, 32'h0);

    // R1 active-high input 1
    wr(2'd0, mword(6'h02, 6'h00, 6'h00));
    fault_i[1] = 1'b0;
    tick(4);
    chk("R1 low level inactive at polarity 1", {31'h0, flag_o[1]}, 32'h0);
    fault_i[1] = 1'b1;
    tick(3);
    chk("R1 high level active at polarity 1", {31'h0, flag_o[1]}, 32'h1);
    fault_i[1] = 1'b0;
    tick(3);

    // R3 filter on input 2
    wr(2'd0, mword(6'h02, 6'h00, 6'h04));
    tick(2);
    fault_i[2] = 1'b0;
    tick(2);
    fault_i[2] = 1'b1;
    tick(8);
    chk("R3 two-cycle pulse rejected", {31'h0, flag_o[2]}, 32'h0);
    fault_i[2] = 1'b0;
    tick(5);
    chk("R3 not before sixth edge", {31'h0, flag_o[2]}, 32'h0);
    tick(1);
    chk("R3 accepted on sixth edge", {31'h0, flag_o[2]}, 32'h1);
    fault_i[2] = 1'b1;
    tick(6);
    chk("R3 filtered release", {31'h0, flag_o[2]}, 32'h0);

    // R5 R6 latched input 3
    wr(2'd0, mword(6'h02, 6'h08, 6'h04));
    fault_i[3] = 1'b0;
    tick(3);
    chk("R5 latched flag sets", {31'h0, flag_o[3]}, 32'h1);
    fault_i[3] = 1'b1;
    tick(6);
    chk("R5 latched flag holds after release", {31'h0, flag_o[3]}, 32'h1);
    fault_i[3] = 1'b0;
    tick(4);
    wr(2'd2, 32'h0000_0008);
    chk("R6 clear during fault ignored", {31'h0, flag_o[3]}, 32'h1);
    fault_i[3] = 1'b1;
    tick(6);
    chk("R6 clear not remembered", {31'h0, flag_o[3]}, 32'h1);
    wr(2'd2, 32'h0000_0008);
    chk("R5 clear after release drops flag", {31'h0, flag_o[3]}, 32'h0);

    // R7 write locks
    wp_sw_i = 1'b1;
    wr(2'd0, 32'h003F_3F3F);
    wp_sw_i = 1'b0;
    rd(2'd0, v);
    chk("R7 software lock blocks write", v, mword(6'h02, 6'h08, 6'h04));
    wp_hw_i = 1'b1;
    wr(2'd0, 32'h0000_0000);
    wp_hw_i = 1'b0;
    rd(2'd0, v);
    chk("R7 hardware lock blocks write", v, mword(6'h02, 6'h08, 6'h04));

    // R8 readback and R9
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v);
    chk("R8 reserved bits read 0", v, 32'h003F_3F3F);
    wr(2'd0, 32'h0000_0000);
    fault_i = 6'h0F;
    tick(3);
    rd(2'd1, v);
    chk("R8 status read", v, 32'h0000_0030);
    chk("R9 any with two flags", {31'h0, fault_any_o}, 32'h1);
    rd(2'd2, v);
    chk("R8 clear register reads 0", v, 32'h0);
    fault_i = 6'h3F;
    tick(3);
    chk("R9 any clears", {31'h0, fault_any_o}, 32'h0);

    // random mix against model
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 3 == 0) fault_i = fault_i ^ 6'(1 << ($urandom % 6));
      wr_en_i = ($urandom % 6 == 0);
      addr_i  = 2'($urandom % 3);
      wdata_i = $urandom;
      wp_sw_i = ($urandom % 4 == 0);
      wp_hw_i = ($urandom % 5 == 0);
      #1;
      case (addr_i)
        2'd0:    chk("R8 R7 mode readback", rdata_o, mword(m_pol, m_mod, m_fil));
        2'd1:    chk("R8 status readback", rdata_o, {26'h0, m_flag});
        default: chk("R8 clear readback", rdata_o, 32'h0);
      endcase
      tick(1);
    end
    wr_en_i = 1'b0;
    tick(2);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule